// File: doc/BRIEF.md
# Horizontal Line Resampling Scaler

This block rescales one lane of a YUV video stream (luma, or one chroma plane) along the horizontal axis. Pixels enter on a valid/ready stream that carries start-of-line and end-of-line markers. They leave on a stream of the same kind, with one line out for each line in. A fractional phase accumulator with 16 fraction bits walks the line. Each output pixel is a blend of two adjacent input pixels, and the blend weight comes from a 64-entry table that software loads.

Software programs a small write-only register file. The file holds an enable bit, a direction bit, a step ratio, a starting phase, an output line length and the weight table. Enable, direction, ratio, phase and length are first held in staging copies. They reach the working set only on an immediate load command, or at the next frame-start pulse if that load was armed beforehand. The meaning of the ratio depends on the direction bit. When enlarging, it is the input step per output pixel, `(in_len-1)*65536/(out_len-1)`. When shrinking, it is the output advance per input pixel, `(out_len-1)*65536/(in_len-1)+1`. For a chroma lane, software uses lengths divided by the horizontal subsampling factor. With enable clear, pixels pass straight through.

Top module: `line_resampler`

## Requirements
- R1: An output pixel that is offered but not taken keeps out_valid high and out_data unchanged until out_ready is seen. An input pixel is consumed only in a cycle where in_valid and in_ready are both high.
- R2: With the working enable bit clear, every input pixel leaves unchanged, with its own start and end markers, on the clock edge after it is accepted.
- R3: In enlarge mode, output k uses the position phase + k*ratio (16 fraction bits). Let a be the input pixel at the integer part of that position and b the pixel after it. Let w be the table entry addressed by the top 6 fraction bits. The output is then a + floor((b-a)*w/64).
- R4: A blend tap that falls past the last input pixel of a line uses the last input pixel instead.
- R5: In enlarge mode, each line yields exactly out_len pixels. The first carries the start marker and the last carries the end marker. Input pixels left over in that line are consumed and discarded.
- R6: In shrink mode, the first input pixel of a line is output unchanged with the start marker. Each later input pixel adds ratio to the accumulator. When that addition carries past 1.0, a pixel is output: the blend of the previous and current input with the weight from table entry 63 minus the top 6 bits of the new fraction. Output stops after out_len pixels (the last one marked end), and the rest of the input line is discarded.
- R7: With phase 0 and the shrink ratio computed by the formula above, shrink mode yields exactly out_len pixels per line (for example 1280 in, 640 out).
- R8: The weight table has 64 entries of 6 bits, and after reset entry i holds i. A write to address 4 sets the table pointer. A write to address 5 stores its low 6 bits at the entry the pointer selects.
- R9: Writes to the staged registers do not change the processing. These are ratio (address 1), phase (address 2), out_len (address 3), and the enable and direction bits of control (address 0: bit 0 enable, bit 1 enlarge). A control write with bit 2 set copies all staged values into the working set at once, including that write's own bits 0 and 1.
- R10: A control write with bit 3 set arms a copy. At the next frame_start pulse the staged values are copied into the working set, and the arm is cleared.
- R11: After reset, out_valid is low, the working enable bit is clear (pass-through) and the table holds the linear ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | FB+1 | Register write data |
| frame_start | input | 1 | One-cycle frame start pulse |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | DW | Input pixel value |
| in_sol | input | 1 | Input start-of-line marker |
| in_eol | input | 1 | Input end-of-line marker |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | DW | Output pixel value |
| out_sol | output | 1 | Output start-of-line marker |
| out_eol | output | 1 | Output end-of-line marker |

## Verification
A wrong accumulator fraction or a wrong pixel pair shows up at once as a wrong blended value, starting with the first output pixel of the line. A wrong integer advance shifts every later pixel, and the per-pixel comparison against the model catches it at the first divergent position. A wrong line counter or drain state shows up at the end of the line as a wrong pixel count or a misplaced end marker. It can also make the next line start from leftover input, which the following test exposes. A load taken at the wrong time leaves a whole line scaled in the wrong mode.

// File: rtl/line_resampler.sv
module line_resampler #(
  parameter int DW = 10,
  parameter int LW = 12,
  parameter int FB = 16,
  parameter int WB = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [FB:0]   cfg_wdata,
  input  logic          frame_start,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sol,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sol,
  output logic          out_eol
);
  localparam int TD = 1 << WB;
  localparam int RW = FB + 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_RATIO = 3'd1, A_PHASE = 3'd2,
                         A_LEN = 3'd3, A_TADDR = 3'd4, A_TDATA = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_NEEDB, S_EMIT, S_RUN, S_DRAIN} st_t;

  logic          sh_en, sh_up, act_en, act_up, arm;
  logic [RW-1:0] sh_ratio, act_ratio;
  logic [FB-1:0] sh_phase, act_phase;
  logic [LW-1:0] sh_len, act_len;
  logic [WB-1:0] tbl_addr;
  logic [WB-1:0] tbl [TD];

  st_t           st;
  logic [DW-1:0] pa, pb;
  logic [FB-1:0] acc;
  logic [LW-1:0] cnt;
  logic          eol_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en <= 1'b0; sh_up <= 1'b0; sh_ratio <= '0; sh_phase <= '0; sh_len <= LW'(1);
      act_en <= 1'b0; act_up <= 1'b0; act_ratio <= '0; act_phase <= '0; act_len <= LW'(1);
      arm <= 1'b0;
      tbl_addr <= '0;
      for (int i = 0; i < TD; i++) tbl[i] <= WB'(i);
    end else begin
      if (frame_start && arm) begin
        act_en <= sh_en; act_up <= sh_up; act_ratio <= sh_ratio;
        act_phase <= sh_phase; act_len <= sh_len; arm <= 1'b0;
      end
      if (cfg_we) begin
        case (cfg_addr)
          A_CTRL: begin
            sh_en <= cfg_wdata[0];
            sh_up <= cfg_wdata[1];
            if (cfg_wdata[2]) begin
              act_en <= cfg_wdata[0]; act_up <= cfg_wdata[1]; act_ratio <= sh_ratio;
              act_phase <= sh_phase; act_len <= sh_len; arm <= 1'b0;
            end
            if (cfg_wdata[3]) arm <= 1'b1;
          end
          A_RATIO: sh_ratio <= cfg_wdata;
          A_PHASE: sh_phase <= cfg_wdata[FB-1:0];
          A_LEN:   sh_len   <= cfg_wdata[LW-1:0];
          A_TADDR: tbl_addr <= cfg_wdata[WB-1:0];
          A_TDATA: tbl[tbl_addr] <= cfg_wdata[WB-1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [DW-1:0] blend(input logic [DW-1:0] p, input logic [DW-1:0] q,
                                          input logic [WB-1:0] w);
    logic signed [DW:0]      d;
    logic signed [DW+WB+1:0] m;
    d = $signed({1'b0, q}) - $signed({1'b0, p});
    m = $signed({{(WB+1){d[DW]}}, d}) * $signed({{(DW+2){1'b0}}, w});
    return p + DW'(m >>> WB);
  endfunction

  logic [FB+1:0] sum;
  logic          carry, last, out_free, fire;
  logic [WB-1:0] w_up, w_dn;

  assign sum      = {2'b00, acc} + {1'b0, act_ratio};
  assign carry    = |sum[FB+1:FB];
  assign last     = (cnt == act_len - LW'(1));
  assign out_free = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign w_up     = tbl[acc[FB-1 -: WB]];
  assign w_dn     = tbl[~sum[FB-1 -: WB]];

  always_comb begin
    case (st)
      S_IDLE, S_RUN:    in_ready = out_free;
      S_NEEDB, S_DRAIN: in_ready = 1'b1;
      default:          in_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      out_valid <= 1'b0; out_data <= '0; out_sol <= 1'b0; out_eol <= 1'b0;
      pa <= '0; pb <= '0; acc <= '0; cnt <= '0; eol_seen <= 1'b0;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      case (st)
        S_IDLE: if (fire) begin
          if (!act_en) begin
            out_valid <= 1'b1; out_data <= in_data; out_sol <= in_sol; out_eol <= in_eol;
          end else if (in_sol) begin
            pa <= in_data; pb <= in_data; acc <= act_phase; eol_seen <= in_eol;
            if (act_up) begin
              cnt <= '0;
              st  <= in_eol ? S_EMIT : S_NEEDB;
            end else begin
              out_valid <= 1'b1; out_data <= in_data; out_sol <= 1'b1;
              out_eol <= (act_len == LW'(1));
              cnt <= LW'(1);
              st  <= in_eol ? S_IDLE : ((act_len == LW'(1)) ? S_DRAIN : S_RUN);
            end
          end
        end
        S_NEEDB: if (fire) begin
          pb <= in_data; eol_seen <= in_eol; st <= S_EMIT;
        end
        S_EMIT: if (out_free) begin
          out_valid <= 1'b1; out_data <= blend(pa, pb, w_up);
          out_sol <= (cnt == '0); out_eol <= last;
          cnt <= cnt + LW'(1);
          if (last) st <= eol_seen ? S_IDLE : S_DRAIN;
          else begin
            acc <= sum[FB-1:0];
            if (carry) begin
              pa <= pb;
              if (!eol_seen) st <= S_NEEDB;
            end
          end
        end
        S_RUN: if (fire) begin
          acc <= sum[FB-1:0]; pa <= in_data;
          if (carry) begin
            out_valid <= 1'b1; out_data <= blend(pa, in_data, w_dn);
            out_sol <= 1'b0; out_eol <= last; cnt <= cnt + LW'(1);
          end
          if (in_eol) st <= S_IDLE;
          else if (carry && last) st <= S_DRAIN;
        end
        S_DRAIN: if (fire && in_eol) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R1
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE && !act_en && in_valid && in_ready |=>
      out_valid && out_data == $past(in_data) && out_eol == $past(in_eol)); // R2
  AST_TBL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == A_TDATA |=> tbl[$past(tbl_addr)] == $past(cfg_wdata[WB-1:0])); // R8
  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == A_CTRL && cfg_wdata[2] |=>
      act_en == $past(cfg_wdata[0]) && act_up == $past(cfg_wdata[1])); // R9
  AST_LOAD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && arm && !(cfg_we && cfg_addr == A_CTRL) |=>
      act_en == $past(sh_en) && act_ratio == $past(sh_ratio) && !arm); // R10
  AST_EMIT_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_EMIT |-> !in_ready); // R5
endmodule

// File: tb/line_resampler_tb.sv
`timescale 1ns/1ps
module line_resampler_tb_top;
  localparam int DW = 10, LW = 12, FB = 16, WB = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, cfg_we, frame_start, in_valid, in_ready, in_sol, in_eol;
  logic          out_valid, out_ready, out_sol, out_eol;
  logic [2:0]    cfg_addr;
  logic [FB:0]   cfg_wdata;
  logic [DW-1:0] in_data, out_data;

  line_resampler #(.DW(DW), .LW(LW), .FB(FB), .WB(WB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sol(in_sol), .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sol(out_sol), .out_eol(out_eol));

  int n_run = 0, n_fail = 0;
  int src [0:2047];
  int exp_d [0:2047];
  int exp_n;
  int got_d [0:2047];
  bit got_s [0:2047];
  bit got_e [0:2047];
  int got_n;
  int tbl_m [0:63];

  task automatic check(input bit ok, input string rq, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
    end
  endtask

  task automatic cfg_wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = (FB+1)'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_fs();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic set_cfg(input bit en, input bit up, input int ratio, input int phase, input int len);
    cfg_wr(1, ratio); cfg_wr(2, phase); cfg_wr(3, len);
    cfg_wr(0, 4 | (int'(up) << 1) | int'(en));
  endtask

  function automatic int r_up(input int nin, input int nout);
    return ((nin - 1) * 65536) / (nout - 1);
  endfunction
  function automatic int r_dn(input int nin, input int nout);
    return ((nout - 1) * 65536) / (nin - 1) + 1;
  endfunction

  function automatic void fill_src(input int n, input int seed);
    for (int i = 0; i < n; i++) src[i] = (i * 37 + seed * 11 + (i * i * 3) % 101) & 1023;
  endfunction

  function automatic int mix(input int a, input int b, input int w);
    return a + (((b - a) * w) >>> 6);
  endfunction

  function automatic void model_pass(input int nin);
    for (int i = 0; i < nin; i++) exp_d[i] = src[i];
    exp_n = nin;
  endfunction

  function automatic void model_up(input int nin, input int ratio, input int phase, input int olen);
    for (int k = 0; k < olen; k++) begin
      longint pos = longint'(phase) + longint'(k) * longint'(ratio);
      int i = int'(pos >> 16);
      int f = int'(pos & 65535);
      int ia = (i > nin - 1) ? nin - 1 : i;
      int ib = (i + 1 > nin - 1) ? nin - 1 : i + 1;
      exp_d[k] = mix(src[ia], src[ib], tbl_m[f >> 10]);
    end
    exp_n = olen;
  endfunction

  function automatic void model_dn(input int nin, input int ratio, input int phase, input int olen);
    int acc = phase;
    int n = 1;
    exp_d[0] = src[0];
    for (int j = 1; j < nin && n < olen; j++) begin
      int s = acc + ratio;
      acc = s & 65535;
      if (s >= 65536) begin
        exp_d[n] = mix(src[j-1], src[j], tbl_m[63 - (acc >> 10)]);
        n++;
      end
    end
    exp_n = n;
  endfunction

  task automatic drive(input int nin);
    int i = 0;
    int c = 0;
    while (i < nin) begin
      @(negedge clk);
      in_valid = (c % 7) != 3; c++;
      in_data = DW'(src[i]); in_sol = (i == 0); in_eol = (i == nin - 1);
      #1;
      if (in_valid && in_ready) begin
        @(posedge clk);
        i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
  endtask

  task automatic collect();
    int idle = 0;
    int c = 0;
    bit done = 1'b0;
    got_n = 0;
    while (!done && idle < 400) begin
      @(negedge clk);
      out_ready = (c % 5) != 2; c++;
      #1;
      if (out_valid && out_ready) begin
        if (got_n < 2048) begin
          got_d[got_n] = int'(out_data); got_s[got_n] = out_sol; got_e[got_n] = out_eol;
        end
        got_n++; idle = 0;
        if (out_eol) done = 1'b1;
      end else idle++;
    end
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic run_line(input int nin);
    fork
      drive(nin);
      collect();
    join
    repeat (3) @(negedge clk);
  endtask

  task automatic compare(input string rq);
    int bad = -1;
    bit mk = 1'b1;
    check(got_n == exp_n, {rq, " count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && got_d[i] != exp_d[i]) bad = i;
    if (bad >= 0) check(1'b0, {rq, " data"}, got_d[bad], exp_d[bad]);
    else check(1'b1, {rq, " data"}, 0, 0);
    for (int i = 0; i < got_n && i < 2048; i++)
      if (got_s[i] != (i == 0) || got_e[i] != (i == got_n - 1)) mk = 1'b0;
    check(mk, {rq, " markers"}, int'(mk), 1);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R11 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R11 idle ready after reset", int'(in_ready), 1);
    fill_src(9, 1); model_pass(9); run_line(9);
    compare("R2 R11 pass-through");
  endtask

  task automatic t_shadow();
    cfg_wr(1, r_up(6, 11)); cfg_wr(2, 0); cfg_wr(3, 11);
    cfg_wr(0, 3);
    fill_src(6, 2); model_pass(6); run_line(6);
    compare("R9 staged only");
    cfg_wr(0, 7);
    model_up(6, r_up(6, 11), 0, 11); run_line(6);
    compare("R9 R3 load now");
  endtask

  task automatic t_up_big();
    set_cfg(1, 1, r_up(640, 1280), 0, 1280);
    fill_src(640, 3); model_up(640, r_up(640, 1280), 0, 1280); run_line(640);
    compare("R3 R1 640->1280");
    check(got_n == 1280, "R5 exact count", got_n, 1280);
  endtask

  task automatic t_edge();
    set_cfg(1, 1, 28086, 32768, 8);
    fill_src(4, 4); model_up(4, 28086, 32768, 8); run_line(4);
    compare("R4 edge");
    check(got_d[7] == src[3], "R4 last tap repeats", got_d[7], src[3]);
  endtask

  task automatic t_up_drain();
    set_cfg(1, 1, 16384, 0, 4);
    fill_src(10, 5); model_up(10, 16384, 0, 4); run_line(10);
    compare("R5 drain line");
    fill_src(10, 6); model_up(10, 16384, 0, 4); run_line(10);
    compare("R5 next line after drain");
  endtask

  task automatic t_down_big();
    set_cfg(1, 0, r_dn(1280, 640), 0, 640);
    fill_src(1280, 7); model_dn(1280, r_dn(1280, 640), 0, 640); run_line(1280);
    compare("R6 R7 1280->640");
    check(got_n == 640, "R7 exact count", got_n, 640);
  endtask

  task automatic t_down_drain();
    set_cfg(1, 0, 30000, 0, 1);
    fill_src(12, 8); model_dn(12, 30000, 0, 1); run_line(12);
    compare("R6 single output");
    set_cfg(1, 0, 40000, 0, 5);
    fill_src(12, 9); model_dn(12, 40000, 0, 5); run_line(12);
    compare("R6 cap at out_len");
  endtask

  task automatic t_table();
    for (int i = 0; i < 64; i++) begin
      cfg_wr(4, i); cfg_wr(5, 0); tbl_m[i] = 0;
    end
    set_cfg(1, 1, r_up(8, 15), 0, 15);
    fill_src(8, 10); model_up(8, r_up(8, 15), 0, 15); run_line(8);
    compare("R8 zero table");
    cfg_wr(4, 40); cfg_wr(5, 63); tbl_m[40] = 63;
    cfg_wr(4, 7);  cfg_wr(5, 21); tbl_m[7] = 21;
    fill_src(8, 11); model_up(8, r_up(8, 15), 0, 15); run_line(8);
    compare("R8 single entries");
    for (int i = 0; i < 64; i++) begin
      cfg_wr(4, i); cfg_wr(5, i); tbl_m[i] = i;
    end
  endtask

  task automatic t_auto();
    set_cfg(1, 1, r_up(6, 11), 0, 11);
    cfg_wr(0, 8);
    fill_src(6, 12); model_up(6, r_up(6, 11), 0, 11); run_line(6);
    compare("R10 armed not yet applied");
    pulse_fs();
    fill_src(6, 13); model_pass(6); run_line(6);
    compare("R10 applied at frame start");
  endtask

  initial begin
    #(4 * 190000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) tbl_m[i] = i;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; frame_start = 1'b0;
    in_valid = 1'b0; in_data = '0; in_sol = 1'b0; in_eol = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shadow();
    t_up_big();
    t_edge();
    t_up_drain();
    t_down_big();
    t_down_drain();
    t_table();
    t_auto();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule